// File: doc/BRIEF.md
# Triggerable Down-Counter/Timer Channel

This block is a single channel of a programmable down-counter. The CPU first writes a control word and then a time constant. Once the time constant is loaded, the channel counts down from it. Each time the count reaches zero, the channel reloads the time constant, raises a one-cycle zero-count pulse and, if enabled, a one-cycle interrupt request.

The channel works in one of two roles, and the control word picks the role.
- In counter mode, every active edge of the external clock/trigger input removes one from the count.
- In timer mode, the count steps once per prescaler period of 16 or 256 system clocks. The timer starts either as soon as the time constant is loaded or on the next active edge of the trigger input.

The active edge, rising or falling, can be selected. The external input passes through a two-stage synchronizer. An edge that meets setup to a clock edge therefore acts at a fixed point two clocks later. An edge that misses setup acts one clock after that.

Top module: `cnt_tmr_chan`

## Requirements
- R1: After reset, zc_o and irq_o are low, and the channel does not count trigger edges until a time constant has been loaded.
- R2: A write with bit 0 = 1 is a control word. Its fields are: bit 7 interrupt enable, bit 6 mode (1 = counter), bit 5 prescaler (1 = 256, 0 = 16), bit 4 edge (1 = rising, 0 = falling), bit 3 trigger start, bit 2 time constant follows, bit 1 software reset. When bit 2 is set, the next write is the time constant. When no time constant is pending, a write with bit 0 = 0 is ignored.
- R3: In counter mode, each active edge of trg_i removes one from the count. If trg_i changes and is first sampled at clock edge k, the decrement happens at edge k+2. A terminal decrement makes zc_o high for the cycle after edge k+2.
- R4: Only the edge direction selected by bit 4 counts; transitions in the other direction have no effect.
- R5: In timer mode without trigger start, for a time constant N loaded at clock edge w with prescale P, zc_o is high in the cycle after edge w+N*P.
- R6: With trigger start (bit 3), the timer stays idle after loading. An active edge first sampled at edge k starts it at edge k+2, and zc_o is then high in the cycle after edge k+2+N*P.
- R7: A time constant of 0 counts as 256.
- R8: On every zero the count reloads from the time constant, so zc_o repeats every N counts.
- R9: zc_o is high for exactly one clock cycle per zero.
- R10: irq_o pulses together with zc_o when bit 7 of the control word is set, and stays low otherwise.
- R11: A control word with bit 1 set stops counting. Counting resumes only after a new time constant is loaded.
- R12: If a time constant is written while the channel is counting and no software reset has been issued, the current count runs on. The new value takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | CPU register write strobe, one cycle per write |
| wr_data_i | input | 8 | Control word or time constant |
| trg_i | input | 1 | External clock/trigger, asynchronous |
| zc_o | output | 1 | Zero-count pulse |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The assertions assume that write strobes are single-cycle pulses and that the trigger input changes no faster than the synchronizer can resolve. They also assume that the edge polarity is not changed while the channel is counting. The stimulus follows these assumptions:
- The bench changes trg_i only on falling clock edges.
- Every level of trg_i is held for at least two cycles.
- Writes are separated by idle cycles.
- A software reset is written before the edge polarity is flipped.

// File: rtl/cnt_tmr_pkg.sv
package cnt_tmr_pkg;
  localparam int CW_IE   = 7;
  localparam int CW_MODE = 6;
  localparam int CW_PSEL = 5;
  localparam int CW_EDGE = 4;
  localparam int CW_TRIG = 3;
  localparam int CW_TCF  = 2;
  localparam int CW_SRST = 1;
  localparam int CW_CTL  = 0;

  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_RUN} chan_st_e;

  typedef struct packed {
    logic ie;
    logic ctr_mode;
    logic psel_hi;
    logic rise;
    logic trig;
  } chan_cfg_t;
endpackage

// File: rtl/cnt_tmr_edge.sv
module cnt_tmr_edge #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trg_i,
  input  logic rise_sel_i,
  output logic edge_o
);
  logic [SYNC_N:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_N-1:0], trg_i};
  end

  // polarity applied after the chain so a select change creates no false edge
  assign edge_o = rise_sel_i ? (sh_q[SYNC_N-1] & ~sh_q[SYNC_N])
                             : (~sh_q[SYNC_N-1] & sh_q[SYNC_N]);
endmodule

// File: rtl/cnt_tmr_presc.sv
module cnt_tmr_presc #(
  parameter int LO_W = 4,
  parameter int HI_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic hi_sel_i,
  output logic tick_o
);
  logic [HI_W-1:0] ps_q;
  logic [HI_W-1:0] lim;

  assign lim    = hi_sel_i ? {HI_W{1'b1}} : {{(HI_W-LO_W){1'b0}}, {LO_W{1'b1}}};
  assign tick_o = run_i && (ps_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ps_q <= '0;
    else if (!run_i) ps_q <= '0;
    else if (tick_o) ps_q <= '0;
    else             ps_q <= ps_q + 1'b1;
  end
endmodule

// File: rtl/cnt_tmr_core.sv
module cnt_tmr_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_val_i,
  output logic             hit_o,
  output logic             zc_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic             zc_q;

  // loaded 0 wraps through all values: 2**CNT_W counts
  assign hit_o = tick_i && (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      zc_q  <= 1'b0;
    end else begin
      zc_q <= hit_o;
      if (load_i)      cnt_q <= load_val_i;
      else if (hit_o)  cnt_q <= reload_val_i;
      else if (tick_i) cnt_q <= cnt_q - ONE;
    end
  end

  assign zc_o  = zc_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/cnt_tmr_chan.sv
module cnt_tmr_chan
  import cnt_tmr_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int PS_LO_W = 4,
  parameter int PS_HI_W = 8,
  parameter int SYNC_N  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             trg_i,
  output logic             zc_o,
  output logic             irq_o
);
  chan_st_e         st_q;
  chan_cfg_t        cfg_q;
  logic [CNT_W-1:0] tc_q;
  logic             tc_pend_q;
  logic             irq_q;

  logic             edge_w, ps_tick_w, tick_w, hit_w, run_w, load_w;
  logic [CNT_W-1:0] cnt_w;

  assign run_w  = (st_q == ST_RUN);
  assign tick_w = run_w && (cfg_q.ctr_mode ? edge_w : ps_tick_w);
  assign load_w = wr_en_i && tc_pend_q && !run_w;

  cnt_tmr_edge #(.SYNC_N(SYNC_N)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trg_i      (trg_i),
    .rise_sel_i (cfg_q.rise),
    .edge_o     (edge_w)
  );

  cnt_tmr_presc #(.LO_W(PS_LO_W), .HI_W(PS_HI_W)) u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_w && !cfg_q.ctr_mode),
    .hi_sel_i (cfg_q.psel_hi),
    .tick_o   (ps_tick_w)
  );

  cnt_tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_w),
    .load_i       (load_w),
    .load_val_i   (wr_data_i),
    .reload_val_i (tc_q),
    .hit_o        (hit_w),
    .zc_o         (zc_o),
    .cnt_o        (cnt_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cfg_q     <= '0;
      tc_q      <= '0;
      tc_pend_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= hit_w && cfg_q.ie;
      if (wr_en_i) begin
        if (tc_pend_q) begin
          tc_q      <= wr_data_i;
          tc_pend_q <= 1'b0;
          // running channel keeps its count; new constant applies at next reload
          if (!run_w)
            st_q <= (cfg_q.ctr_mode || !cfg_q.trig) ? ST_RUN : ST_ARMED;
        end else if (wr_data_i[CW_CTL]) begin
          cfg_q.ie       <= wr_data_i[CW_IE];
          cfg_q.ctr_mode <= wr_data_i[CW_MODE];
          cfg_q.psel_hi  <= wr_data_i[CW_PSEL];
          cfg_q.rise     <= wr_data_i[CW_EDGE];
          cfg_q.trig     <= wr_data_i[CW_TRIG];
          tc_pend_q      <= wr_data_i[CW_TCF];
          if (wr_data_i[CW_SRST]) st_q <= ST_IDLE;
        end
      end else if (st_q == ST_ARMED && edge_w) begin
        st_q <= ST_RUN;
      end
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/cnt_tmr_chan_chk.sv
module cnt_tmr_chan_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             zc_i,
  input logic             irq_i,
  input logic             run_i,
  input logic             tick_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] tc_i
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  a_r9_zc_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zc_i |=> !zc_i);

  a_r10_irq_with_zc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> zc_i);

  a_r11_stopped_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !zc_i);

  a_r3_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_i != ONE) |=> ($past(cnt_i) == cnt_i + ONE));

  a_r8_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zc_i |-> (cnt_i == $past(tc_i)));
endmodule

bind cnt_tmr_chan cnt_tmr_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .zc_i   (zc_o),
  .irq_i  (irq_o),
  .run_i  (run_w),
  .tick_i (tick_w),
  .cnt_i  (cnt_w),
  .tc_i   (tc_q)
);

// File: tb/cnt_tmr_chan_tb_top.sv
`timescale 1ns/1ps
module cnt_tmr_chan_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       trg = 1'b0;
  logic       zc, irq;
  int         n_chk = 0;
  int         n_fail = 0;
  int         zc_seen = 0;
  int         irq_seen = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  cnt_tmr_chan dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .trg_i(trg), .zc_o(zc), .irq_o(irq)
  );

  always @(negedge clk) begin
    if (rst_n && zc)  zc_seen++;
    if (rst_n && irq) irq_seen++;
  end

  task automatic check(input int act, input int exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one active edge; zc checked in the cycle after edge k+2
  task automatic edge_chk(input logic act, input logic exp, input string tag);
    @(negedge clk); trg = act;
    @(negedge clk);
    @(negedge clk); trg = ~act;
    check(zc, 0, tag);
    @(negedge clk); check(zc, exp, tag);
    @(negedge clk); if (exp) check(zc, 0, "R9 pulse width");
  endtask

  task automatic t_reset;
    int z0;
    check(zc, 0, "R1 zc after reset");
    check(irq, 0, "R1 irq after reset");
    z0 = zc_seen;
    for (int i = 0; i < 3; i++) begin edge_chk(1'b1, 1'b0, "R1 no count"); end
    check(zc_seen - z0, 0, "R1 edges ignored");
  endtask

  task automatic t_counter_rise;
    wr(8'hD7); wr(8'd3);
    edge_chk(1'b1, 1'b0, "R3 edge1");
    edge_chk(1'b1, 1'b0, "R3 edge2");
    @(negedge clk); trg = 1'b1;
    idle(2); trg = 1'b0;
    check(zc, 0, "R3 before terminal");
    @(negedge clk);
    check(zc, 1, "R3 terminal timing");
    check(irq, 1, "R10 irq with zc");
    idle(1);
    wr(8'h00);
    edge_chk(1'b1, 1'b0, "R2 ignored write e1");
    edge_chk(1'b1, 1'b0, "R2 ignored write e2");
    edge_chk(1'b1, 1'b1, "R2 R8 reload period");
  endtask

  task automatic t_counter_fall;
    int i0;
    wr(8'h47);
    trg = 1'b1; idle(4);
    i0 = irq_seen;
    wr(8'd2);
    edge_chk(1'b0, 1'b0, "R4 falling e1");
    edge_chk(1'b0, 1'b1, "R4 falling e2");
    check(irq_seen - i0, 0, "R10 irq disabled");
  endtask

  task automatic t_tc_zero;
    int z0;
    wr(8'h57);
    trg = 1'b0; idle(4);
    wr(8'd0);
    z0 = zc_seen;
    for (int i = 0; i < 255; i++) begin
      @(negedge clk); trg = 1'b1; idle(2); trg = 1'b0; idle(2);
    end
    check(zc_seen - z0, 0, "R7 no zero before 256");
    edge_chk(1'b1, 1'b1, "R7 zero at 256");
  endtask

  task automatic t_tc_update;
    wr(8'h57); wr(8'd4);
    edge_chk(1'b1, 1'b0, "R12 first");
    wr(8'h55); wr(8'd2);
    edge_chk(1'b1, 1'b0, "R12 old count a");
    edge_chk(1'b1, 1'b0, "R12 old count b");
    edge_chk(1'b1, 1'b1, "R12 old count ends");
    edge_chk(1'b1, 1'b0, "R12 new a");
    edge_chk(1'b1, 1'b1, "R12 new constant used");
  endtask

  task automatic t_timer16;
    wr(8'h07); wr(8'd4);
    idle(63); check(zc, 0, "R5 before 64");
    idle(1);  check(zc, 1, "R5 at 64");
    idle(64); check(zc, 1, "R8 timer repeat");
  endtask

  task automatic t_timer256;
    wr(8'h27); wr(8'd2);
    idle(511); check(zc, 0, "R5 before 512");
    idle(1);   check(zc, 1, "R5 at 512");
  endtask

  task automatic t_trigger;
    int z0;
    wr(8'h1F); wr(8'd2);
    z0 = zc_seen;
    idle(100);
    check(zc_seen - z0, 0, "R6 waits for trigger");
    @(negedge clk); trg = 1'b1;
    idle(34); check(zc, 0, "R6 before");
    idle(1);  check(zc, 1, "R6 triggered timing");
    trg = 1'b0;
  endtask

  task automatic t_swreset;
    int z0;
    wr(8'h03);
    z0 = zc_seen;
    idle(200);
    check(zc_seen - z0, 0, "R11 stopped");
    wr(8'h05); wr(8'd1);
    idle(15); check(zc, 0, "R11 restart before");
    idle(1);  check(zc, 1, "R11 restart after tc");
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_counter_rise();
    t_counter_fall();
    t_tc_zero();
    t_tc_update();
    t_timer16();
    t_timer256();
    t_trigger();
    t_swreset();
    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule